// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sequences a successive-approximation analog-to-digital converter that sits on the byte bus of a small microcontroller. Software reaches it through four byte registers: control, clock select, result high and result low. The control register holds a start bit, a busy flag and a 6-bit channel/pin configuration field. The clock-select register holds the converter clock divider choice, a test bit and the interrupt request flag.

A conversion is armed when software writes the start bit from 0 to 1, and it begins when the bit is written back to 0. A prescaler divides the system clock to make the converter tick. On each tick the sequencer holds one sample cycle and then resolves one bit per tick, from MSB to LSB. It presents each trial code on `dac_code` and reads the answer on the digital comparator input `cmp_in`. When the sequence ends, the result registers update together, the busy flag drops and the interrupt request flag is set.

The state machine has five states. S_IDLE moves to S_ARMED on a start rise. S_ARMED moves to S_SAMPLE on a start fall. S_SAMPLE moves to S_CONV on a tick. S_CONV moves to S_DONE on the tick that resolves bit 0. S_DONE moves to S_IDLE, or to S_ARMED if a start rise arrives in that cycle. A start rise in S_SAMPLE or S_CONV aborts the conversion and returns the machine to S_ARMED.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_out` is 0.
- R2: A write to the control register (address 0) with bit 7 = 1 while the stored start bit is 0 sets the busy flag (control bit 6) from the next cycle. Busy stays 1 while start remains 1.
- R3: A write to address 0 with bit 7 = 0 while the stored start bit is 1 begins a conversion. Busy reads 1 for 10·D cycles after that write edge and reads 0 from cycle 10·D+1, where D is the selected divide ratio.
- R4: Clock-select (address 1) bits 1:0 choose D: 00 gives 2, 01 gives 8, 10 gives 32, 11 gives 4.
- R5: With `cmp_in` = 1 whenever the input level is at or above `dac_code`, the 9-bit result equals the input level for every level from 0 to 511.
- R6: Address 2 reads result bits 8..1 in bits 7..0. Address 3 reads result bit 0 in bit 7, and its bits 6..0 read as 0.
- R7: Completion sets the interrupt flag (address 1, bit 6). A write to address 1 with bit 6 = 0 clears the flag, and a write with bit 6 = 1 leaves it unchanged. `irq_out` equals the flag AND `irq_en`.
- R8: A start rise during a conversion aborts it. The result registers keep their old value, busy stays 1, and a new conversion with full latency runs after the next start fall.
- R9: Address 1 bit 7 is a test bit. It reads back as written and changes neither latency nor result.
- R10: Control bits 5..0 read back as written, so writing 0x20 reads back 0x20 in those bits. Bit 6 ignores writes.
- R11: The result registers change only at the completion of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 clock select, 2 result high, 3 result low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| dac_code | output | 9 | Current successive-approximation trial code |
| irq_en | input | 1 | Interrupt enable |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
Every input level from 0 to 511 is converted at the fastest divider. This separates a correct MSB-to-LSB decision path from one with a stuck, swapped or off-by-one bit, and it checks the uneven high/low packing on every code. A few levels are repeated at each of the other divider codes, and once with the test bit set. Because the exact busy-to-idle latency is checked in each case, a wrong divide ratio, a missing sample cycle or an extra step shows up as a latency error. The abort pattern restarts a conversion partway through and tells a true restart apart from a resumed or prematurely committed one. Separate write patterns to the clock-select register tell a clearing write apart from one that leaves the interrupt flag alone.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_SAMPLE,
        S_CONV,
        S_DONE
    } sar_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CLK  = 2'd1;
    localparam logic [1:0] ADDR_RHI  = 2'd2;
    localparam logic [1:0] ADDR_RLO  = 2'd3;
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
    parameter int DIV_00 = 2,
    parameter int DIV_01 = 8,
    parameter int DIV_10 = 32,
    parameter int DIV_11 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAX_A = (DIV_00 > DIV_01) ? DIV_00 : DIV_01;
    localparam int MAX_B = (DIV_10 > DIV_11) ? DIV_10 : DIV_11;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_D + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        unique case (sel)
            2'b00: last = CW'(DIV_00 - 1);
            2'b01: last = CW'(DIV_01 - 1);
            2'b10: last = CW'(DIV_10 - 1);
            2'b11: last = CW'(DIV_11 - 1);
            default: last = CW'(DIV_00 - 1);
        endcase
    end

    assign tick = (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_rise,
    input  logic             start_fall,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             done,
    output logic             cnt_clr,
    output logic [RES_W-1:0] sar
);
    localparam int IW = $clog2(RES_W);

    sar_state_t       state, state_n;
    logic [IW-1:0]    idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start_rise) state_n = S_ARMED;
            S_ARMED:  if (start_fall) state_n = S_SAMPLE;
            S_SAMPLE: if (start_rise) state_n = S_ARMED;
                      else if (tick)  state_n = S_CONV;
            S_CONV:   if (start_rise) state_n = S_ARMED;
                      else if (tick && idx == '0) state_n = S_DONE;
            S_DONE:   state_n = start_rise ? S_ARMED : S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        cnt_clr = (state == S_ARMED) || (state == S_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar <= '0;
            idx <= '0;
        end else if (state == S_SAMPLE && tick && !start_rise) begin
            sar          <= '0;
            sar[RES_W-1] <= 1'b1;
            idx          <= IW'(RES_W - 1);
        end else if (state == S_CONV && tick && !start_rise) begin
            if (!cmp_in)   sar[idx]        <= 1'b0;
            if (idx != '0) sar[idx - 1'b1] <= 1'b1;
            idx <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 9,
    parameter int DIV_00 = 2,
    parameter int DIV_01 = 8,
    parameter int DIV_10 = 32,
    parameter int DIV_11 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    input  logic             irq_en,
    output logic             irq_out
);
    localparam int LO_BITS = RES_W - 8;
    localparam int LO_PAD  = 8 - LO_BITS;

    logic             start_q, test_q, irq_q;
    logic [5:0]       cfg_q;
    logic [1:0]       sel_q;
    logic [RES_W-1:0] res_q;
    logic             wr_ctrl, wr_clk, start_rise, start_fall;
    logic             tick, busy, done, cnt_clr;
    logic [RES_W-1:0] sar;

    assign wr_ctrl    = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_clk     = bus_we && (bus_addr == ADDR_CLK);
    assign start_rise = wr_ctrl &&  bus_wdata[7] && !start_q;
    assign start_fall = wr_ctrl && !bus_wdata[7] &&  start_q;

    adc_clkdiv #(
        .DIV_00(DIV_00), .DIV_01(DIV_01), .DIV_10(DIV_10), .DIV_11(DIV_11)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .sel(sel_q), .tick(tick)
    );

    adc_sar_fsm #(.RES_W(RES_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_rise(start_rise),
        .start_fall(start_fall), .tick(tick), .cmp_in(cmp_in),
        .busy(busy), .done(done), .cnt_clr(cnt_clr), .sar(sar)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            cfg_q   <= '0;
            sel_q   <= '0;
            test_q  <= 1'b0;
            irq_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                start_q <= bus_wdata[7];
                cfg_q   <= bus_wdata[5:0];
            end
            if (wr_clk) begin
                sel_q  <= bus_wdata[1:0];
                test_q <= bus_wdata[7];
            end
            if (done)                        irq_q <= 1'b1;
            else if (wr_clk && !bus_wdata[6]) irq_q <= 1'b0;
            if (done) res_q <= sar;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {start_q, busy, cfg_q};
            ADDR_CLK:  bus_rdata = {test_q, irq_q, 4'b0000, sel_q};
            ADDR_RHI:  bus_rdata = res_q[RES_W-1:LO_BITS];
            ADDR_RLO:  bus_rdata = {res_q[LO_BITS-1:0], {LO_PAD{1'b0}}};
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign dac_code = sar;
    assign irq_out  = irq_q && irq_en;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             start_q,
    input logic             busy,
    input logic             done,
    input logic             irq_q,
    input logic [RES_W-1:0] res_q
);
    // R2
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0 && bus_wdata[7] && !start_q) |=> busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy);

    // R7
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_q);

    // R7
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1 && !bus_wdata[6] && !done) |=> !irq_q);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_q) |-> $past(busy));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .start_q(start_q), .busy(busy), .done(done),
    .irq_q(irq_q), .res_q(res_q)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [8:0] dac_code;
    logic       irq_en = 1'b0;
    logic       irq_out;
    int         vin = 0;
    logic       cmp_in;
    int         checks = 0;
    int         fails = 0;
    bit         finished = 0;

    assign cmp_in = (vin >= int'(dac_code));

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .irq_en(irq_en), .irq_out(irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int div_of(input logic [1:0] s);
        case (s)
            2'b00: return 2;
            2'b01: return 8;
            2'b10: return 32;
            default: return 4;
        endcase
    endfunction

    task automatic wait_idle(output int k);
        bus_addr = 2'd0;
        k = 0;
        for (int i = 1; i < 2000; i++) begin
            @(negedge clk);
            #1;
            if (!bus_rdata[6]) begin k = i; break; end
        end
    endtask

    task automatic convert(input logic [1:0] s, input int v, input logic tbit);
        logic [7:0] d;
        int k;
        wr(2'd1, {tbit, 5'b00000, s});
        vin = v;
        wr(2'd0, 8'hA0);
        rd(2'd0, d);
        check("R2 busy after start rise", d[6], 1);
        wr(2'd0, 8'h20);
        wait_idle(k);
        check("R3/R4 latency", k, 10 * div_of(s) + 1);
        rd(2'd2, d);
        check("R5/R6 high byte", d, v >> 1);
        rd(2'd3, d);
        check("R5/R6 low byte", d, (v & 1) << 7);
    endtask

    initial begin
        logic [7:0] d;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 reset register", d, 0);
        end
        check("R1 irq_out", irq_out, 0);

        // R10 config readback and bit 6 ignored
        wr(2'd0, 8'h47);
        rd(2'd0, d);
        check("R10 ctrl readback", d, 8'h07);
        wr(2'd0, 8'h20);
        rd(2'd0, d);
        check("R10 config 0x20", d, 8'h20);

        // R5 full sweep at fastest divider
        for (int v = 0; v < 512; v++) convert(2'b00, v, 1'b0);
        // R4 other dividers
        for (int s = 1; s < 4; s++) begin
            convert(s[1:0], 0, 1'b0);
            convert(s[1:0], 341, 1'b0);
            convert(s[1:0], 511, 1'b0);
        end
        // R9 test bit
        convert(2'b01, 170, 1'b1);
        rd(2'd1, d);
        check("R9 test bit readback", d[7], 1);

        // R7 interrupt flag
        rd(2'd1, d);
        check("R7 flag set", d[6], 1);
        check("R7 irq_out gated off", irq_out, 0);
        irq_en = 1'b1;
        #1 check("R7 irq_out enabled", irq_out, 1);
        wr(2'd1, 8'h41);
        rd(2'd1, d);
        check("R7 write one keeps flag", d[6], 1);
        wr(2'd1, 8'h01);
        rd(2'd1, d);
        check("R7 write zero clears", d[6], 0);
        check("R7 irq_out cleared", irq_out, 0);

        // R8 abort and restart
        convert(2'b01, 100, 1'b0);
        vin = 300;
        wr(2'd0, 8'hA0);
        wr(2'd0, 8'h20);
        repeat (30) @(negedge clk);
        wr(2'd0, 8'hA0);
        rd(2'd2, d);
        check("R8 R11 result held on abort", d, 50);
        repeat (40) @(negedge clk);
        rd(2'd0, d);
        check("R8 busy while re-armed", d[6], 1);
        wr(2'd0, 8'h20);
        rd(2'd2, d);
        check("R11 result held while running", d, 50);
        bus_addr = 2'd0;
        wait_idle(k);
        check("R8 restart latency", k + 1, 81);
        rd(2'd2, d);
        check("R8 new high byte", d, 150);
        rd(2'd3, d);
        check("R8 new low byte", d, 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule